// File: doc/BRIEF.md
# Serial Configuration Loader for a Dual Tone Detector

This block receives configuration words from a host microcontroller over a three-wire, write-only serial link: an active-low select, a serial clock and a data line. All three pins are asynchronous to the system clock. The block brings them into the system clock domain and counts the bits of each frame. When the select line is released and the frame has the correct length, it decodes the frame into settings for two detector channels. Each channel gets a 5-bit gain code, a 2-bit bandwidth code and a frequency select. There is also one flag that routes both channels from the first input amplifier.

A static mode pin chooses between two frame formats. The compatibility format is 6 bits long and gives both channels one shared setting. The enhanced format is 16 bits long and sets each channel on its own. It also carries a 2-bit system-select field, which sets both the channel frequencies and the input sharing.

Each accepted frame updates the held settings and raises a one-cycle change strobe. A gain code that is not allowed with a 16 kHz selection is clamped, and the error output is set. The link carries no stream data. There is no valid/ready handshake and no back-pressure, and the host cannot read the settings back. The mode pin may only change while the select line is high and no frame is in flight.

Top module: `spm_cfg_loader`

## Requirements
- R1: After reset, both channels hold gain 00000, bandwidth 00 and the 12 kHz select (f12 = 1). The sharing flag, the change strobe and the error output are all 0.
- R2: In compatibility mode (enh_mode = 0), a 6-bit frame is shifted in most significant bit first. Bits 5..1 become the gain of both channels. Bit 0 becomes the frequency select of both channels, where 1 means 12 kHz and 0 means 16 kHz.
- R3: In compatibility mode, an accepted frame sets both bandwidth codes to 00 (±1.5%) and clears the sharing flag.
- R4: In enhanced mode (enh_mode = 1), a 16-bit frame is shifted in most significant bit first. Bits 15..11 are the channel-2 gain, bits 10..9 the channel-2 bandwidth, bits 8..4 the channel-1 gain, bits 3..2 the channel-1 bandwidth and bits 1..0 the system select. Bandwidth codes 00, 01, 10 and 11 stand for ±1.5%, ±3%, ±5% and ±7.5%.
- R5: The system select sets the frequencies, given here as channel 1 / channel 2 with f12 = 1 meaning 12 kHz. Code 00 gives 16/16, codes 01 and 10 give 16/12, and code 11 gives 12/12.
- R6: The sharing flag is 1 after an enhanced frame with system select 10, and 0 after any other accepted frame.
- R7: A frame whose bit count differs from the mode's length (6 or 16) changes no output and raises no strobe. This includes frames longer than the mode's length.
- R8: Serial clock edges while the select line is high shift nothing. They do not affect the next frame.
- R9: A channel selected for 16 kHz that receives a gain from 11000 to 11011 holds 10111 instead. The error output is 1 after such a frame. The next accepted frame without a clamp sets it back to 0.
- R10: Outputs change only together with cfg_changed. cfg_changed is high for exactly one cycle per accepted frame, on the third rising system-clock edge after cfg_csn rises.
- R11: Each serial pin passes through a two-flop synchroniser. The frame decodes correctly when each serial-clock phase lasts at least two system-clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enh_mode | input | 1 | Frame format: 0 = 6-bit shared, 1 = 16-bit per channel |
| cfg_csn | input | 1 | Serial select, active low, asynchronous |
| cfg_sck | input | 1 | Serial clock; data is taken on its rising edge |
| cfg_sdi | input | 1 | Serial data, most significant bit first |
| ch1_gain | output | 5 | Channel-1 gain code |
| ch1_bw | output | 2 | Channel-1 bandwidth code |
| ch1_f12 | output | 1 | Channel-1 frequency select: 1 = 12 kHz, 0 = 16 kHz |
| ch2_gain | output | 5 | Channel-2 gain code |
| ch2_bw | output | 2 | Channel-2 bandwidth code |
| ch2_f12 | output | 1 | Channel-2 frequency select: 1 = 12 kHz, 0 = 16 kHz |
| in_shared | output | 1 | Both channels fed from input amplifier 1 |
| cfg_changed | output | 1 | One-cycle strobe on each accepted frame |
| cfg_error | output | 1 | The last accepted frame had a gain clamped |

## Verification
The assertions check several properties on every cycle:
- no channel ever holds a forbidden gain while set to 16 kHz;
- sharing only appears with the 16 kHz / 12 kHz frequency split;
- the outputs stay still whenever the strobe is low, and the strobe never lasts two cycles;
- a compatibility-mode update leaves the channels identical, with narrow bandwidth.

Some properties need the serial sequences the bench drives, so only its scenarios can show them: the bit-to-field mapping, MSB-first ordering, rejection of short and long frames, immunity to stray clocks while the select line is high, and the exact three-cycle strobe latency.

// File: rtl/spm_cfg_pkg.sv
package spm_cfg_pkg;
  localparam int GAIN_W    = 5;
  localparam int BW_W      = 2;
  localparam int SEL_W     = 2;
  localparam int SHORT_LEN = GAIN_W + 1;
  localparam int LONG_LEN  = 2 * (GAIN_W + BW_W) + SEL_W;
  localparam int CNT_W     = $clog2(LONG_LEN + 2);

  localparam logic [GAIN_W-1:0] BAN_LO    = 5'b11000;
  localparam logic [GAIN_W-1:0] BAN_HI    = 5'b11011;
  localparam logic [GAIN_W-1:0] CLAMP_VAL = 5'b10111;

  localparam logic [SEL_W-1:0] SEL_BOTH16 = 2'b00;
  localparam logic [SEL_W-1:0] SEL_SPLIT  = 2'b01;
  localparam logic [SEL_W-1:0] SEL_SHARED = 2'b10;
  localparam logic [SEL_W-1:0] SEL_BOTH12 = 2'b11;

  typedef struct packed {
    logic [GAIN_W-1:0] gain;
    logic [BW_W-1:0]   bw;
    logic              f12;
  } chan_cfg_t;

  typedef struct packed {
    chan_cfg_t ch2;
    chan_cfg_t ch1;
    logic      shared_in;
  } cfg_t;

  localparam chan_cfg_t CHAN_RST = '{gain: '0, bw: '0, f12: 1'b1};
  localparam cfg_t      CFG_RST  = '{ch2: CHAN_RST, ch1: CHAN_RST, shared_in: 1'b0};

  function automatic logic banned(input chan_cfg_t c);
    return !c.f12 && (c.gain >= BAN_LO) && (c.gain <= BAN_HI);
  endfunction
endpackage

// File: rtl/cfg_sync_edge.sv
module cfg_sync_edge #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic [W-1:0] rise
);
  logic [STAGES-1:0][W-1:0] pipe;
  logic [W-1:0]             last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= {STAGES{RST_VAL}};
      last <= RST_VAL;
    end else begin
      pipe[0] <= din;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      last <= pipe[STAGES-1];
    end
  end

  assign q    = pipe[STAGES-1];
  assign rise = pipe[STAGES-1] & ~last;
endmodule

// File: rtl/cfg_shift_capture.sv
module cfg_shift_capture
  import spm_cfg_pkg::*;
#(
  parameter int LEN = LONG_LEN,
  parameter int CW  = $clog2(LEN + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          csn_s,
  input  logic          sck_rise,
  input  logic          sdi_s,
  output logic [LEN-1:0] shreg,
  output logic [CW-1:0]  nbits
);
  localparam logic [CW-1:0] SAT = CW'(LEN + 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      nbits <= '0;
    end else if (csn_s) begin
      nbits <= '0;
    end else if (sck_rise) begin
      shreg <= {shreg[LEN-2:0], sdi_s};
      if (nbits != SAT) nbits <= nbits + 1'b1;
    end
  end
endmodule

// File: rtl/cfg_frame_decode.sv
module cfg_frame_decode
  import spm_cfg_pkg::*;
(
  input  logic [LONG_LEN-1:0] shreg,
  input  logic [CNT_W-1:0]    nbits,
  input  logic                enh_mode,
  output cfg_t                cfg,
  output logic                len_ok,
  output logic                clamped
);
  chan_cfg_t        c1, c2;
  logic [SEL_W-1:0] sel;
  logic             shr, k1, k2;

  always_comb begin
    sel = shreg[SEL_W-1:0];
    shr = 1'b0;
    if (enh_mode) begin
      c2.gain = shreg[LONG_LEN-1 -: GAIN_W];
      c2.bw   = shreg[LONG_LEN-GAIN_W-1 -: BW_W];
      c1.gain = shreg[SEL_W+BW_W +: GAIN_W];
      c1.bw   = shreg[SEL_W +: BW_W];
      c1.f12  = (sel == SEL_BOTH12);
      c2.f12  = (sel != SEL_BOTH16);
      shr     = (sel == SEL_SHARED);
      len_ok  = (nbits == CNT_W'(LONG_LEN));
    end else begin
      c1.gain = shreg[SHORT_LEN-1:1];
      c1.bw   = '0;
      c1.f12  = shreg[0];
      c2      = c1;
      len_ok  = (nbits == CNT_W'(SHORT_LEN));
    end
    k1 = banned(c1);
    k2 = banned(c2);
    if (k1) c1.gain = CLAMP_VAL;
    if (k2) c2.gain = CLAMP_VAL;
    clamped = k1 | k2;
    cfg     = '{ch2: c2, ch1: c1, shared_in: shr};
  end
endmodule

// File: rtl/spm_cfg_loader.sv
module spm_cfg_loader
  import spm_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enh_mode,
  input  logic              cfg_csn,
  input  logic              cfg_sck,
  input  logic              cfg_sdi,
  output logic [GAIN_W-1:0] ch1_gain,
  output logic [BW_W-1:0]   ch1_bw,
  output logic              ch1_f12,
  output logic [GAIN_W-1:0] ch2_gain,
  output logic [BW_W-1:0]   ch2_bw,
  output logic              ch2_f12,
  output logic              in_shared,
  output logic              cfg_changed,
  output logic              cfg_error
);
  // pin order inside the synchroniser: {csn, sck, sdi}
  logic [2:0]          pins_q, pins_rise;
  logic [LONG_LEN-1:0] shreg;
  logic [CNT_W-1:0]    nbits;
  cfg_t                dec_cfg, cfg_q;
  logic                len_ok, clamped, err_q, chg_q;

  cfg_sync_edge #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk (clk), .rst_n (rst_n),
    .din ({cfg_csn, cfg_sck, cfg_sdi}),
    .q (pins_q), .rise (pins_rise)
  );

  cfg_shift_capture #(.LEN(LONG_LEN), .CW(CNT_W)) u_shift (
    .clk (clk), .rst_n (rst_n),
    .csn_s (pins_q[2]), .sck_rise (pins_rise[1]), .sdi_s (pins_q[0]),
    .shreg (shreg), .nbits (nbits)
  );

  cfg_frame_decode u_dec (
    .shreg (shreg), .nbits (nbits), .enh_mode (enh_mode),
    .cfg (dec_cfg), .len_ok (len_ok), .clamped (clamped)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RST;
      err_q <= 1'b0;
      chg_q <= 1'b0;
    end else begin
      chg_q <= 1'b0;
      if (pins_rise[2] && len_ok) begin
        cfg_q <= dec_cfg;
        err_q <= clamped;
        chg_q <= 1'b1;
      end
    end
  end

  assign ch1_gain    = cfg_q.ch1.gain;
  assign ch1_bw      = cfg_q.ch1.bw;
  assign ch1_f12     = cfg_q.ch1.f12;
  assign ch2_gain    = cfg_q.ch2.gain;
  assign ch2_bw      = cfg_q.ch2.bw;
  assign ch2_f12     = cfg_q.ch2.f12;
  assign in_shared   = cfg_q.shared_in;
  assign cfg_changed = chg_q;
  assign cfg_error   = err_q;
endmodule

// File: rtl/spm_cfg_loader_chk.sv
module spm_cfg_loader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enh_mode,
  input logic [4:0] ch1_gain,
  input logic [1:0] ch1_bw,
  input logic       ch1_f12,
  input logic [4:0] ch2_gain,
  input logic [1:0] ch2_bw,
  input logic       ch2_f12,
  input logic       in_shared,
  input logic       cfg_changed,
  input logic       cfg_error
);
  a_r9_no_banned_ch1: assert property (@(posedge clk) disable iff (!rst_n)
    !ch1_f12 |-> !(ch1_gain >= 5'b11000 && ch1_gain <= 5'b11011));

  a_r9_no_banned_ch2: assert property (@(posedge clk) disable iff (!rst_n)
    !ch2_f12 |-> !(ch2_gain >= 5'b11000 && ch2_gain <= 5'b11011));

  a_r9_error_has_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_error |-> ((!ch1_f12 && ch1_gain == 5'b10111) || (!ch2_f12 && ch2_gain == 5'b10111)));

  a_r6_shared_split: assert property (@(posedge clk) disable iff (!rst_n)
    in_shared |-> (!ch1_f12 && ch2_f12));

  a_r10_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_changed |=> !cfg_changed);

  a_r10_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_changed |-> $stable({ch1_gain, ch1_bw, ch1_f12, ch2_gain, ch2_bw, ch2_f12,
                              in_shared, cfg_error}));

  a_r3_compat_uniform: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_changed && !enh_mode) |-> (ch1_gain == ch2_gain && ch1_f12 == ch2_f12 &&
                                    ch1_bw == 2'b00 && ch2_bw == 2'b00 && !in_shared));
endmodule

bind spm_cfg_loader spm_cfg_loader_chk u_chk (
  .clk (clk), .rst_n (rst_n), .enh_mode (enh_mode),
  .ch1_gain (ch1_gain), .ch1_bw (ch1_bw), .ch1_f12 (ch1_f12),
  .ch2_gain (ch2_gain), .ch2_bw (ch2_bw), .ch2_f12 (ch2_f12),
  .in_shared (in_shared), .cfg_changed (cfg_changed), .cfg_error (cfg_error)
);

// File: tb/spm_cfg_loader_bench.sv
`timescale 1ns/1ps
module spm_cfg_loader_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, enh_mode, cfg_csn, cfg_sck, cfg_sdi;
  logic [4:0] ch1_gain, ch2_gain;
  logic [1:0] ch1_bw, ch2_bw;
  logic ch1_f12, ch2_f12, in_shared, cfg_changed, cfg_error;

  spm_cfg_loader u_spm_cfg_loader (
    .clk (clk), .rst_n (rst_n), .enh_mode (enh_mode),
    .cfg_csn (cfg_csn), .cfg_sck (cfg_sck), .cfg_sdi (cfg_sdi),
    .ch1_gain (ch1_gain), .ch1_bw (ch1_bw), .ch1_f12 (ch1_f12),
    .ch2_gain (ch2_gain), .ch2_bw (ch2_bw), .ch2_f12 (ch2_f12),
    .in_shared (in_shared), .cfg_changed (cfg_changed), .cfg_error (cfg_error)
  );

  int total = 0, bad = 0;
  string cur_req = "R1";
  bit check_on = 0;

  // reference model state: held (m_) and next (n_) values
  int m_g1, m_g2, m_b1, m_b2, m_f1, m_f2, m_sh, m_err, m_chg;
  int n_g1, n_g2, n_b1, n_b2, n_f1, n_f2, n_sh, n_err;
  int pend = 0;

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    m_chg = 0;
    if (!rst_n) begin
      m_g1 = 0; m_g2 = 0; m_b1 = 0; m_b2 = 0; m_f1 = 1; m_f2 = 1; m_sh = 0; m_err = 0;
      pend = 0;
    end else if (pend > 0) begin
      if (pend == 1) begin
        m_g1 = n_g1; m_g2 = n_g2; m_b1 = n_b1; m_b2 = n_b2;
        m_f1 = n_f1; m_f2 = n_f2; m_sh = n_sh; m_err = n_err; m_chg = 1;
      end
      pend--;
    end
  end

  always @(negedge clk) begin
    if (check_on) begin
      chk(cur_req, "ch1_gain", ch1_gain, m_g1);
      chk(cur_req, "ch2_gain", ch2_gain, m_g2);
      chk(cur_req, "ch1_bw", ch1_bw, m_b1);
      chk(cur_req, "ch2_bw", ch2_bw, m_b2);
      chk(cur_req, "ch1_f12", ch1_f12, m_f1);
      chk(cur_req, "ch2_f12", ch2_f12, m_f2);
      chk(cur_req, "in_shared", in_shared, m_sh);
      chk(cur_req, "cfg_error", cfg_error, m_err);
      chk("R10", "cfg_changed", cfg_changed, m_chg);
    end
  end

  function automatic int clampg(int g, int f12, ref int hit);
    if (f12 == 0 && g >= 24 && g <= 27) begin hit = 1; return 23; end
    return g;
  endfunction

  task automatic predict(logic [31:0] bits, int n);
    int hit = 0;
    if (!enh_mode && n == 6) begin
      n_f1 = bits[0]; n_f2 = bits[0];
      n_g1 = clampg(int'(bits[5:1]), n_f1, hit); n_g2 = n_g1;
      n_b1 = 0; n_b2 = 0; n_sh = 0; n_err = hit;
      pend = 3;
    end else if (enh_mode && n == 16) begin
      case (bits[1:0])
        2'b00: begin n_f1 = 0; n_f2 = 0; n_sh = 0; end
        2'b01: begin n_f1 = 0; n_f2 = 1; n_sh = 0; end
        2'b10: begin n_f1 = 0; n_f2 = 1; n_sh = 1; end
        default: begin n_f1 = 1; n_f2 = 1; n_sh = 0; end
      endcase
      n_g2 = clampg(int'(bits[15:11]), n_f2, hit);
      n_g1 = clampg(int'(bits[8:4]), n_f1, hit);
      n_b2 = int'(bits[10:9]); n_b1 = int'(bits[3:2]);
      n_err = hit;
      pend = 3;
    end
  endtask

  task automatic send(string req, logic [31:0] bits, int n, int half);
    cur_req = req;
    @(negedge clk) cfg_csn = 1'b0;
    repeat (half) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      cfg_sdi = bits[i];
      repeat (half) @(negedge clk);
      cfg_sck = 1'b1;
      repeat (half) @(negedge clk);
      cfg_sck = 1'b0;
    end
    repeat (half) @(negedge clk);
    cfg_csn = 1'b1;
    predict(bits, n);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    #600000;
    bad++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; enh_mode = 1'b0; cfg_csn = 1'b1; cfg_sck = 1'b0; cfg_sdi = 1'b0;
    repeat (2) @(negedge clk);
    check_on = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "reset ch1_gain", ch1_gain, 0);
    chk("R1", "reset ch2_f12", ch2_f12, 1);
    chk("R1", "reset strobe", cfg_changed, 0);

    // compatibility frames
    send("R2", 32'b010011, 6, 4);                 // gain 01001, 12 kHz
    chk("R2", "compat gain", ch1_gain, 9);
    send("R2", 32'b001100, 6, 4);                 // gain 00110, 16 kHz
    chk("R2", "compat f12", ch2_f12, 0);
    send("R9", 32'b110010, 6, 4);                 // banned 11001 at 16 kHz -> 10111
    chk("R9", "clamp gain", ch2_gain, 23);
    chk("R9", "clamp flag", cfg_error, 1);
    send("R9", 32'b110101, 6, 4);                 // 11010 at 12 kHz allowed, flag clears
    chk("R9", "no clamp at 12k", ch1_gain, 26);
    chk("R9", "flag cleared", cfg_error, 0);
    send("R3", 32'b111111, 6, 4);
    chk("R3", "compat bw", ch1_bw, 0);

    // wrong lengths in compatibility mode
    send("R7", 32'b10101, 5, 4);
    send("R7", 32'b1000001, 7, 4);
    chk("R7", "short/long ignored", ch1_gain, 31);

    // stray clocks with select high, then a good frame
    cur_req = "R8";
    for (int i = 0; i < 12; i++) begin
      cfg_sdi = i[0];
      repeat (4) @(negedge clk); cfg_sck = 1'b1;
      repeat (4) @(negedge clk); cfg_sck = 1'b0;
    end
    send("R8", 32'b000101, 6, 4);
    chk("R8", "frame after stray clocks", ch1_gain, 2);

    // enhanced frames
    enh_mode = 1'b1;
    repeat (4) @(negedge clk);
    send("R4", {16'b0, 5'b01001, 2'b01, 5'b00101, 2'b10, 2'b11}, 16, 4);
    chk("R4", "ch2 gain field", ch2_gain, 9);
    chk("R4", "ch1 bw field", ch1_bw, 2);
    send("R5", {16'b0, 5'b00111, 2'b11, 5'b00110, 2'b00, 2'b00}, 16, 4);
    chk("R5", "sel 00 ch2", ch2_f12, 0);
    send("R5", {16'b0, 5'b10000, 2'b10, 5'b00001, 2'b01, 2'b01}, 16, 4);
    chk("R5", "sel 01 ch2", ch2_f12, 1);
    send("R6", {16'b0, 5'b00011, 2'b00, 5'b01100, 2'b11, 2'b10}, 16, 4);
    chk("R6", "sel 10 shared", in_shared, 1);
    send("R6", {16'b0, 5'b00011, 2'b00, 5'b01100, 2'b11, 2'b11}, 16, 4);
    chk("R6", "sel 11 unshared", in_shared, 0);
    send("R9", {16'b0, 5'b11000, 2'b00, 5'b11011, 2'b01, 2'b00}, 16, 4);
    chk("R9", "both clamped", ch1_gain, 23);
    send("R9", {16'b0, 5'b11011, 2'b00, 5'b11010, 2'b01, 2'b01}, 16, 4);
    chk("R9", "ch1 clamped ch2 kept", ch2_gain, 27);
    send("R7", 32'h0000_7FFF, 15, 4);
    send("R7", 32'h0001_FFFF, 17, 4);
    send("R7", 32'b111111, 6, 4);
    chk("R7", "wrong enh length", ch2_gain, 27);
    send("R11", {16'b0, 5'b10110, 2'b01, 5'b01011, 2'b10, 2'b11}, 16, 2);
    chk("R11", "fast serial clock", ch1_gain, 11);
    send("R10", {16'b0, 5'b00000, 2'b00, 5'b00000, 2'b00, 2'b11}, 16, 2);

    repeat (10) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule